// File: doc/BRIEF.md
# Single-precision floating-point multiplier

This block takes two binary32 operands and returns their product as a binary32 word. The result is rounded to nearest, with ties going to even. The datapath is pipelined over two register stages. The first stage sorts each operand into a class (zero, normal, infinity or NaN), forms the sign, adds the biased exponents, and multiplies the two 24-bit significands, each with its hidden one restored. The second stage normalises the product with at most one right shift, then rounds it using guard, round and sticky bits. It corrects the exponent if rounding carries out, and finally resolves the special cases and range limits.

A new operand pair may be presented every cycle together with `valid_i`. The matching result appears two clock edges later with `valid_o` high, along with three flags: overflow, underflow and invalid operation. Subnormal inputs are treated as zero, and results below the normal range flush to a signed zero.

Top module: `fmul32`

## Requirements
- R1: Operand and result layout is sign at bit 31, biased exponent (bias 127) at bits 30:23 and fraction at bits 22:0. A product of two normal operands whose result stays in range is returned with no flag set, with exponent E1 + E2 − 127 (plus one when the significand product is 2 or more); for example 0x40400000 × 0x40A00000 gives 0x41700000.
- R2: The sign of every non-NaN result is the XOR of the operand signs, including zero and infinity results.
- R3: When the final biased exponent is 255 or more, the result is a correctly signed infinity (exponent 0xFF, fraction 0) with `overflow_o` high.
- R4: When the final biased exponent is 0 or less, the result is a correctly signed zero with `underflow_o` high.
- R5: Rounding is to nearest. If the bits below the kept LSB are above half, the result rounds up. If they are below half, it truncates. If they are exactly half, it rounds to the even fraction.
- R6: When rounding carries out of the fraction, the fraction becomes zero and the exponent increments; for example 0x3FFFFFFE × 0x3F800001 gives 0x40000000.
- R7: A NaN operand, or infinity times zero, returns 0x7FC00000 with `invalid_o` high and the other two flags low. At most one flag is ever high.
- R8: Infinity times a normal value or infinity returns a signed infinity with no flag set.
- R9: An operand whose exponent field is 0 (zero or subnormal), multiplied by a normal value or zero, returns a signed zero with no flag set.
- R10: `valid_o` rises exactly two rising edges after `valid_i` is sampled high, one result per cycle. After reset, `valid_o`, `result_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair valid this cycle |
| a_i | input | 32 | First operand, binary32 |
| b_i | input | 32 | Second operand, binary32 |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Rounded product, binary32 |
| overflow_o | output | 1 | Result exceeded the normal range |
| underflow_o | output | 1 | Result fell below the normal range and was flushed |
| invalid_o | output | 1 | NaN operand or infinity times zero |

## Verification
Random operands almost never land exactly on a half-ulp tie, and they almost never round a fraction of all ones up into a new leading bit. These paths are the hardest to reach from the ports. The stimulus therefore includes operand pairs whose significand products were chosen by hand: one sits exactly half an ulp above an odd fraction, one sits half an ulp above an even fraction, and one sits just under 2.0 with guard and round bits set. The random stream biases exponent fields so that their sum straddles both range limits, which exercises overflow and underflow alongside in-range products.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;
endpackage

// File: rtl/fmul_classify.sv
module fmul_classify
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output logic                  sign_o,
  output fp_cls_e               cls_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W:0]       sig_o
);
  logic [FRAC_W-1:0] frac;

  assign sign_o = op_i[EXP_W+FRAC_W];
  assign exp_o  = op_i[FRAC_W +: EXP_W];
  assign frac   = op_i[FRAC_W-1:0];
  assign sig_o  = {1'b1, frac};

  always_comb begin
    if (exp_o == '0)       cls_o = CLS_ZERO;  // subnormals treated as zero
    else if (&exp_o)       cls_o = (frac == '0) ? CLS_INF : CLS_NAN;
    else                   cls_o = CLS_NORM;
  end
endmodule

// File: rtl/fmul_norm_round.sv
module fmul_norm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int ESW    = EXP_W + 2
) (
  input  logic [PROD_W-1:0]     prod_i,
  input  logic signed [ESW-1:0] exp_i,
  output logic [FRAC_W-1:0]     frac_o,
  output logic signed [ESW-1:0] exp_o
);
  logic              top;
  logic [PROD_W-2:0] norm;
  logic [FRAC_W-1:0] kept;
  logic              guard, rnd, sticky, round_up;
  logic [FRAC_W:0]   sum;

  // product lies in [1,4): one right shift at most
  assign top  = prod_i[PROD_W-1];
  assign norm = top ? prod_i[PROD_W-2:0] : {prod_i[PROD_W-3:0], 1'b0};

  assign kept   = norm[PROD_W-2 -: FRAC_W];
  assign guard  = norm[PROD_W-2-FRAC_W];
  assign rnd    = norm[PROD_W-3-FRAC_W];
  assign sticky = |norm[PROD_W-4-FRAC_W:0];

  assign round_up = guard & (rnd | sticky | kept[0]);
  assign sum      = {1'b0, kept} + (FRAC_W+1)'(round_up);

  // carry out leaves an all-zero fraction and bumps the exponent
  assign frac_o = sum[FRAC_W-1:0];
  assign exp_o  = exp_i + ESW'(top) + ESW'(sum[FRAC_W]);
endmodule

// File: rtl/fmul_resolve.sv
module fmul_resolve
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int ESW   = EXP_W + 2
) (
  input  logic                  sign_i,
  input  fp_cls_e               cls_a_i,
  input  fp_cls_e               cls_b_i,
  input  logic signed [ESW-1:0] exp_i,
  input  logic [FRAC_W-1:0]     frac_i,
  output logic [W-1:0]          result_o,
  output logic                  ovf_o,
  output logic                  udf_o,
  output logic                  inv_o
);
  localparam logic signed [ESW-1:0] EXP_TOP = ESW'(2**EXP_W - 1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic any_nan, any_inf, any_zero;

  assign any_nan  = (cls_a_i == CLS_NAN)  || (cls_b_i == CLS_NAN);
  assign any_inf  = (cls_a_i == CLS_INF)  || (cls_b_i == CLS_INF);
  assign any_zero = (cls_a_i == CLS_ZERO) || (cls_b_i == CLS_ZERO);

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    udf_o    = 1'b0;
    inv_o    = 1'b0;
    if (any_nan || (any_inf && any_zero)) begin
      result_o = QNAN;
      inv_o    = 1'b1;
    end else if (any_inf) begin
      result_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (any_zero) begin
      result_o = {sign_i, {(W-1){1'b0}}};
    end else if (exp_i >= EXP_TOP) begin
      result_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_o    = 1'b1;
    end else if (exp_i <= 0) begin
      result_o = {sign_i, {(W-1){1'b0}}};
      udf_o    = 1'b1;
    end else begin
      result_o = {sign_i, exp_i[EXP_W-1:0], frac_i};
    end
  end
endmodule

// File: rtl/fmul32.sv
module fmul32
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int ESW    = EXP_W + 2,
  localparam int BIAS   = 2**(EXP_W-1) - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         overflow_o,
  output logic         underflow_o,
  output logic         invalid_o
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // stage 0: classify both operands
  logic [W-1:0]       ops  [2];
  logic               sgn  [2];
  fp_cls_e            cls  [2];
  logic [EXP_W-1:0]   expf [2];
  logic [SIG_W-1:0]   sig  [2];

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fmul_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i  (ops[g]),
      .sign_o(sgn[g]),
      .cls_o (cls[g]),
      .exp_o (expf[g]),
      .sig_o (sig[g])
    );
  end

  logic [PROD_W-1:0]     prod_d;
  logic signed [ESW-1:0] exp_d;

  assign prod_d = PROD_W'(sig[0]) * PROD_W'(sig[1]);
  assign exp_d  = ESW'(expf[0]) + ESW'(expf[1]) - ESW'(BIAS);

  // stage 1 registers
  logic                  v1_q, sign1_q;
  fp_cls_e               cla1_q, clb1_q;
  logic [PROD_W-1:0]     prod1_q;
  logic signed [ESW-1:0] exp1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      sign1_q <= 1'b0;
      cla1_q  <= CLS_ZERO;
      clb1_q  <= CLS_ZERO;
      prod1_q <= '0;
      exp1_q  <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        sign1_q <= sgn[0] ^ sgn[1];
        cla1_q  <= cls[0];
        clb1_q  <= cls[1];
        prod1_q <= prod_d;
        exp1_q  <= exp_d;
      end
    end
  end

  // stage 2: normalise, round, resolve
  logic [FRAC_W-1:0]     frac_r;
  logic signed [ESW-1:0] exp_r;
  logic [W-1:0]          res_d;
  logic                  ovf_d, udf_d, inv_d;

  fmul_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .prod_i(prod1_q),
    .exp_i (exp1_q),
    .frac_o(frac_r),
    .exp_o (exp_r)
  );

  fmul_resolve #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_resolve (
    .sign_i  (sign1_q),
    .cls_a_i (cla1_q),
    .cls_b_i (clb1_q),
    .exp_i   (exp_r),
    .frac_i  (frac_r),
    .result_o(res_d),
    .ovf_o   (ovf_d),
    .udf_o   (udf_d),
    .inv_o   (inv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      invalid_o   <= 1'b0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) begin
        result_o    <= res_d;
        overflow_o  <= ovf_d;
        underflow_o <= udf_d;
        invalid_o   <= inv_d;
      end
    end
  end

  // normal x normal significand product lies in [1,4)
  assert_prod_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && cla1_q == CLS_NORM && clb1_q == CLS_NORM) |-> (prod1_q[PROD_W-1:PROD_W-2] != 2'b00));

  assert_sign_xor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !invalid_o) |-> (result_o[W-1] == $past(sign1_q)));

  assert_ovf_inf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (result_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  assert_udf_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (result_o[W-2:0] == '0));

  assert_nan_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (result_o == QNAN));

  assert_flag_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({overflow_o, underflow_o, invalid_o}));
endmodule

// File: tb/fmul32_test.sv
module fmul32_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 400;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o, overflow_o, underflow_o, invalid_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fmul32 uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .result_o(result_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o), .invalid_o(invalid_o)
  );

  // {ovf, udf, inv, result}
  function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, e, sh;
    logic [22:0] fa, fb;
    logic a_nan, b_nan, a_inf, b_inf, a_z, b_z;
    logic [63:0] p, q, rem, half;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    fa = a[22:0]; fb = b[22:0];
    a_nan = (ea == 255) && (fa != 0); b_nan = (eb == 255) && (fb != 0);
    a_inf = (ea == 255) && (fa == 0); b_inf = (eb == 255) && (fb == 0);
    a_z = (ea == 0); b_z = (eb == 0);
    if (a_nan || b_nan || ((a_inf || b_inf) && (a_z || b_z))) return {3'b001, 32'h7FC00000};
    if (a_inf || b_inf) return {3'b000, s, 8'hFF, 23'd0};
    if (a_z || b_z) return {3'b000, s, 31'd0};
    p = 64'({1'b1, fa}) * 64'({1'b1, fb});
    e = ea + eb - 127;
    if (p >= (64'd1 << 47)) begin sh = 24; e = e + 1; end
    else sh = 23;
    q    = p >> sh;
    rem  = p & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && q[0])) q = q + 64'd1;
    if (q == (64'd1 << 24)) begin q = q >> 1; e = e + 1; end
    if (e >= 255) return {3'b100, s, 8'hFF, 23'd0};
    if (e <= 0)   return {3'b010, s, 31'd0};
    return {3'b000, s, 8'(e), q[22:0]};
  endfunction

  function automatic string tag_of(input logic [34:0] x);
    if (x[32]) return "R7";
    if (x[34]) return "R3";
    if (x[33]) return "R4";
    return "R1";
  endfunction

  function automatic logic [31:0] rand_op();
    logic [31:0] r;
    int unsigned sel;
    r   = $urandom;
    sel = $urandom % 8;
    if (sel == 0) return r;
    if (sel == 1) r[30:23] = 8'(1 + $urandom % 24);
    else          r[30:23] = 8'(64 + $urandom % 128);
    return r;
  endfunction

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] a, input logic [31:0] b,
                         input logic [34:0] exp, input string req);
    @(negedge clk_i);
    a_i = a; b_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    check({req, " valid"}, 35'(valid_o), 35'd1);
    check(req, {overflow_o, underflow_o, invalid_o, result_o}, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      finish_run();
    end
  end

  logic [31:0] ra [N_RAND];
  logic [31:0] rb [N_RAND];
  logic [34:0] rx [N_RAND];

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 reset", {valid_o, overflow_o, underflow_o, invalid_o, result_o}, 35'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 idle", 35'(valid_o), 35'd0);

    // R10 latency: single pulse
    a_i = 32'h40400000; b_i = 32'h40A00000; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R10 one edge", 35'(valid_o), 35'd0);
    @(negedge clk_i);
    check("R10 two edges", 35'(valid_o), 35'd1);
    check("R1 3x5", {overflow_o, underflow_o, invalid_o, result_o}, {3'b000, 32'h41700000});
    @(negedge clk_i);
    check("R10 drop", 35'(valid_o), 35'd0);

    run_one(32'hC0400000, 32'h40A00000, {3'b000, 32'hC1700000}, "R2 neg x pos");
    run_one(32'h3F800001, 32'h3FC00000, {3'b000, 32'h3FC00002}, "R5 tie odd");
    run_one(32'h3F800003, 32'h3FC00000, {3'b000, 32'h3FC00004}, "R5 tie even");
    run_one(32'h3FFFFFFE, 32'h3F800001, {3'b000, 32'h40000000}, "R6 carry");
    run_one(32'h7F000000, 32'h7F000000, {3'b100, 32'h7F800000}, "R3 ovf");
    run_one(32'hFF000000, 32'h7F000000, {3'b100, 32'hFF800000}, "R3 ovf neg");
    run_one(32'h7F7FFFFF, 32'h3F800001, {3'b100, 32'h7F800000}, "R3 ovf norm");
    run_one(32'h7F000000, 32'h3F800000, {3'b000, 32'h7F000000}, "R3 edge 254");
    run_one(32'h00800000, 32'h00800000, {3'b010, 32'h00000000}, "R4 udf");
    run_one(32'h80800000, 32'h3F000000, {3'b010, 32'h80000000}, "R4 udf exp0");
    run_one(32'h00800000, 32'h3F800000, {3'b000, 32'h00800000}, "R4 edge 1");
    run_one(32'h7F800001, 32'h3F800000, {3'b001, 32'h7FC00000}, "R7 nan");
    run_one(32'h7F800000, 32'h80000000, {3'b001, 32'h7FC00000}, "R7 inf x 0");
    run_one(32'h007FFFFF, 32'hFF800000, {3'b001, 32'h7FC00000}, "R7 inf x denorm");
    run_one(32'h7F800000, 32'hC0000000, {3'b000, 32'hFF800000}, "R8 inf x -2");
    run_one(32'hFF800000, 32'hFF800000, {3'b000, 32'h7F800000}, "R8 inf x inf");
    run_one(32'h807FFFFF, 32'h40000000, {3'b000, 32'h80000000}, "R9 denorm");
    run_one(32'h00000000, 32'hC0000000, {3'b000, 32'h80000000}, "R9 zero sign");

    // back-to-back random stream, one result per cycle
    for (int i = 0; i < N_RAND; i++) begin
      ra[i] = rand_op();
      rb[i] = rand_op();
      rx[i] = model(ra[i], rb[i]);
    end
    for (int i = 0; i < N_RAND + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        check("R10 stream valid", 35'(valid_o), 35'd1);
        check(tag_of(rx[i-2]), {overflow_o, underflow_o, invalid_o, result_o}, rx[i-2]);
      end
      if (i < N_RAND) begin
        a_i = ra[i]; b_i = rb[i]; valid_i = 1'b1;
      end else begin
        valid_i = 1'b0;
      end
    end
    @(negedge clk_i);
    check("R10 stream end", 35'(valid_o), 35'd0);
    done = 1'b1;
    finish_run();
  end
endmodule